// File: doc/BRIEF.md
# Interrupt Virtual-Wire Message Generator

This block folds the level-sensitive, active-low legacy interrupt pins of several downstream bus segments onto four upstream virtual interrupt wires, numbered A to D. Each segment has four pins and a device number. The device number rotates the segment's pins before they are merged onto the wires. A virtual wire is asserted while at least one of the sources mapped to it is asserted.

The block watches the four virtual wires. Whenever a wire's level differs from the level last reported upstream, it raises a request. Requests leave one at a time over a valid/ready handshake. Each request carries the wire index and a flag that says Assert or Deassert. A packet layer downstream of the block turns these requests into link messages.

Top module: `intx_vwire_gen`

## Requirements
- R1: Pin p (A=0, B=1, C=2, D=3) of a segment whose device number is d drives virtual wire (p + d) mod 4. Only the two low bits of d matter. The message reports the wire on `msg_wire_o` with A=0 through D=3.
- R2: A pin is asserted when it is low. A virtual wire is asserted when any source mapped to it is asserted.
- R3: When a virtual wire goes from deasserted to asserted, one message goes out for that wire with `msg_assert_o`=1.
- R4: When a virtual wire goes from asserted to deasserted, one message goes out for that wire with `msg_assert_o`=0.
- R5: If a source changes but the OR of its wire does not change, no message is produced.
- R6: Every pin passes through a two-flop synchronizer. Take an idle block and a pin change applied before clock edge 1. `msg_valid_o` is low after edge 2 and high after edge 3.
- R7: While `msg_valid_o` is high and `msg_ready_i` is low, `msg_valid_o`, `msg_wire_o` and `msg_assert_o` hold their values.
- R8: When several wires have pending messages, they are issued in round-robin order A, B, C, D, A and so on. The search starts at the wire after the one issued last.
- R9: A wire may toggle back to its last reported level before its message is loaded for issue. In that case the pending message is dropped and nothing is sent for it.
- R10: After reset, `msg_valid_o` is low and every wire counts as deasserted. A pin that is already low when reset is released therefore produces an Assert message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| int_n_i | input | NUM_SEG*4 | Active-low interrupt pins, four per segment, pin A in the low bit of each group |
| dev_num_i | input | NUM_SEG*DEV_W | Device number of each segment |
| msg_valid_o | output | 1 | A message request is presented |
| msg_ready_i | input | 1 | The consumer accepts the request |
| msg_wire_o | output | 2 | Virtual wire index, A=0 to D=3 |
| msg_assert_o | output | 1 | 1 = Assert message, 0 = Deassert message |

## Verification
The bench builds the block with NUM_SEG=3 instead of the default 4, and with DEV_W=5. The three segments use device numbers 0, 5 and 6. Because 5 and 6 are larger than 3, the tests show that only the two low bits of the device number select the rotation. The different rotations also put pins from two segments onto the same wire, which lets the bench test OR merging and the quiet cases of R5.

Holding `msg_ready_i` low lets the bench queue several wires at once. This exposes the round-robin order and the dropping of double toggles.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int unsigned NUM_WIRES = 4;
  localparam int unsigned WIRE_W    = 2;

  typedef logic [WIRE_W-1:0] wire_idx_t;

  typedef enum logic {
    MSG_DEASSERT = 1'b0,
    MSG_ASSERT   = 1'b1
  } msg_kind_t;
endpackage

// File: rtl/intx_sync.sv
module intx_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= {WIDTH{RST_VAL}};
      sync_q <= {WIDTH{RST_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/intx_swizzle.sv
module intx_swizzle
  import intx_pkg::*;
#(
  parameter int unsigned NUM_SEG = 4,
  parameter int unsigned DEV_W   = 5
) (
  input  logic [NUM_SEG-1:0][NUM_WIRES-1:0] pin_n_i,
  input  logic [NUM_SEG-1:0][DEV_W-1:0]     dev_num_i,
  output logic [NUM_WIRES-1:0]              wire_o
);
  // rotation by device number, merged by OR
  always_comb begin
    wire_o = '0;
    for (int s = 0; s < NUM_SEG; s++) begin
      for (int p = 0; p < NUM_WIRES; p++) begin
        for (int v = 0; v < NUM_WIRES; v++) begin
          if (!pin_n_i[s][p] &&
              (WIRE_W'(p) + dev_num_i[s][WIRE_W-1:0]) == WIRE_W'(v))
            wire_o[v] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/intx_wire_track.sv
module intx_wire_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wire_i,
  input  logic load_i,
  output logic pending_o
);
  logic reported_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     reported_q <= 1'b0;
    else if (load_i) reported_q <= wire_i;
  end

  // level differs from what upstream was last told
  assign pending_o = wire_i ^ reported_q;

  AST_LOAD_ONLY_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> pending_o); // R9
endmodule

// File: rtl/intx_rr_arb.sv
module intx_rr_arb
  import intx_pkg::*;
(
  input  logic [NUM_WIRES-1:0] req_i,
  input  wire_idx_t            last_i,
  output logic [NUM_WIRES-1:0] gnt_o,
  output wire_idx_t            idx_o,
  output logic                 any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = last_i;
    any_o = 1'b0;
    for (int i = 1; i <= NUM_WIRES; i++) begin
      if (!any_o && req_i[WIRE_W'(int'(last_i) + i)]) begin
        any_o = 1'b1;
        idx_o = WIRE_W'(int'(last_i) + i);
        gnt_o[WIRE_W'(int'(last_i) + i)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intx_vwire_gen.sv
module intx_vwire_gen
  import intx_pkg::*;
#(
  parameter int unsigned NUM_SEG = 4,
  parameter int unsigned DEV_W   = 5
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_SEG-1:0][NUM_WIRES-1:0]  int_n_i,
  input  logic [NUM_SEG-1:0][DEV_W-1:0]      dev_num_i,
  output logic                               msg_valid_o,
  input  logic                               msg_ready_i,
  output logic [WIRE_W-1:0]                  msg_wire_o,
  output logic                               msg_assert_o
);
  localparam int unsigned PIN_CNT = NUM_SEG * NUM_WIRES;

  logic [PIN_CNT-1:0]               pin_sync;
  logic [NUM_SEG-1:0][NUM_WIRES-1:0] pin_n;
  logic [NUM_WIRES-1:0]             vwire, pending, gnt;
  wire_idx_t                        gnt_idx, last_q, out_wire_q;
  msg_kind_t                        out_kind_q;
  logic                             gnt_any, out_valid_q, can_load, load;

  intx_sync #(.WIDTH(PIN_CNT), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (int_n_i),
    .q_o   (pin_sync)
  );
  assign pin_n = pin_sync;

  intx_swizzle #(.NUM_SEG(NUM_SEG), .DEV_W(DEV_W)) u_swz (
    .pin_n_i  (pin_n),
    .dev_num_i(dev_num_i),
    .wire_o   (vwire)
  );

  for (genvar w = 0; w < NUM_WIRES; w++) begin : g_track
    intx_wire_track u_track (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wire_i   (vwire[w]),
      .load_i   (load && gnt[w]),
      .pending_o(pending[w])
    );
  end

  intx_rr_arb u_arb (
    .req_i (pending),
    .last_i(last_q),
    .gnt_o (gnt),
    .idx_o (gnt_idx),
    .any_o (gnt_any)
  );

  assign can_load = !out_valid_q || msg_ready_i;
  assign load     = can_load && gnt_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_wire_q  <= '0;
      out_kind_q  <= MSG_DEASSERT;
      last_q      <= wire_idx_t'(NUM_WIRES - 1);
    end else if (load) begin
      out_valid_q <= 1'b1;
      out_wire_q  <= gnt_idx;
      out_kind_q  <= msg_kind_t'(vwire[gnt_idx]);
      last_q      <= gnt_idx;
    end else if (msg_ready_i) begin
      out_valid_q <= 1'b0;
    end
  end

  assign msg_valid_o  = out_valid_q;
  assign msg_wire_o   = out_wire_q;
  assign msg_assert_o = out_kind_q;

  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_wire_o) && $stable(msg_assert_o)); // R7
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt)); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> $past(|pending)); // R3
endmodule

// File: tb/intx_vwire_gen_test.sv
module intx_vwire_gen_test;
  localparam int NSEG = 3;
  localparam int DW   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSEG-1:0][3:0]    pins = '1;
  logic [NSEG-1:0][DW-1:0] devs;
  logic       ready = 1'b0;
  logic       valid, kind;
  logic [1:0] wire_idx;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  intx_vwire_gen #(.NUM_SEG(NSEG), .DEV_W(DW)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .int_n_i     (pins),
    .dev_num_i   (devs),
    .msg_valid_o (valid),
    .msg_ready_i (ready),
    .msg_wire_o  (wire_idx),
    .msg_assert_o(kind)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_pin(input int s, input int p, input logic v);
    @(negedge clk);
    pins[s][p] = v;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 12 && !valid; i++) @(negedge clk);
  endtask

  // check presented message and accept it
  task automatic take(input string req, input int w, input int k);
    wait_valid();
    chk({req, " valid"}, int'(valid), 1);
    chk({req, " wire"}, int'(wire_idx), w);
    chk({req, " kind"}, int'(kind), k);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic quiet(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (valid) seen = 1;
    end
    chk({req, " quiet"}, seen, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 valid in reset", int'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_latency();
    @(negedge clk);
    pins[0][0] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R6 valid after edge 2", int'(valid), 0);
    @(negedge clk);
    chk("R6 valid after edge 3", int'(valid), 1);
    take("R3 assert A", 0, 1);
    set_pin(0, 0, 1'b1);
    take("R4 deassert A", 0, 0);
    quiet("R4 single msg", 6);
  endtask

  task automatic t_swizzle();
    set_pin(1, 0, 1'b0);          // dev 5 -> A to B
    take("R1 seg1 pinA", 1, 1);
    set_pin(1, 0, 1'b1);
    take("R1 seg1 pinA off", 1, 0);
    set_pin(2, 3, 1'b0);          // dev 6 -> D to B
    take("R1 seg2 pinD", 1, 1);
    set_pin(2, 3, 1'b1);
    take("R1 seg2 pinD off", 1, 0);
    set_pin(1, 3, 1'b0);          // dev 5 -> D to A
    take("R1 seg1 pinD", 0, 1);
    set_pin(1, 3, 1'b1);
    take("R1 seg1 pinD off", 0, 0);
  endtask

  task automatic t_or();
    set_pin(0, 1, 1'b0);          // B
    take("R2 first source", 1, 1);
    set_pin(1, 0, 1'b0);          // also B
    quiet("R5 second source", 8);
    set_pin(0, 1, 1'b1);
    quiet("R5 one released", 8);
    set_pin(1, 0, 1'b1);
    take("R2 last released", 1, 0);
  endtask

  task automatic t_rr();
    set_pin(0, 2, 1'b0);          // C held
    wait_valid();
    @(negedge clk);
    pins[0][0] = 1'b0; pins[0][1] = 1'b0; pins[0][3] = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R7 hold valid", int'(valid), 1);
      chk("R7 hold wire", int'(wire_idx), 2);
    end
    take("R8 first C", 2, 1);
    take("R8 then D", 3, 1);
    take("R8 then A", 0, 1);
    take("R8 then B", 1, 1);
    @(negedge clk);
    pins[0] = 4'hF;
    repeat (4) @(negedge clk);
    take("R8 deassert C", 2, 0);
    take("R8 deassert D", 3, 0);
    take("R8 deassert A", 0, 0);
    take("R8 deassert B", 1, 0);
  endtask

  task automatic t_cancel();
    set_pin(0, 0, 1'b0);
    wait_valid();
    set_pin(0, 1, 1'b0);
    repeat (5) @(negedge clk);
    pins[0][1] = 1'b1;
    repeat (6) @(negedge clk);
    take("R9 held A", 0, 1);
    quiet("R9 B dropped", 8);
    set_pin(0, 0, 1'b1);
    take("R9 release A", 0, 0);
  endtask

  task automatic t_reset_low();
    rst_n = 1'b0;
    @(negedge clk);
    pins[2][0] = 1'b0;            // dev 6 -> A to C
    do_reset();
    take("R10 assert after reset", 2, 1);
    set_pin(2, 0, 1'b1);
    take("R10 release", 2, 0);
  endtask

  initial begin
    devs[0] = 5'd0; devs[1] = 5'd5; devs[2] = 5'd6;
    do_reset();
    quiet("R10 idle", 5);
    t_latency();
    t_swizzle();
    t_or();
    t_rr();
    t_cancel();
    t_reset_low();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule